// File: doc/BRIEF.md
# Register-Array LIFO Stack with Full and Empty Flags

This block is a last-in first-out store of 64 words, each 16 bits wide, held in a bank of registers. A 6-bit pointer always names the location of the item on top. Two one-bit flag registers report whether the stack is full or empty. A client pushes by pulsing a push strobe with a word on the data input. It pops by pulsing a pop strobe. The popped word then appears on the data output one cycle later and stays there until the next accepted pop.

The pointer wraps around. A push advances the pointer first and then writes at the new location. A pop reads the top location first and then steps the pointer back. Location 0 is therefore used last and holds the 64th item. The pointer reads zero in two states: the empty state and the full state. The flags tell these two states apart.

Some requests are refused. A push into a full stack and a pop from an empty stack both leave every piece of state unchanged, and each raises a one-cycle error pulse. A cycle that strobes push and pop together is also refused: nothing moves, and no error pulse is raised.

Top module: `reg_stack`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, err_o is 0 and dout_o is 0.
- R2: Accepted pops return the accepted pushed words in reverse order of their pushes, over the whole 64-entry depth.
- R3: An accepted push forces empty_o to 0 on the next cycle. The pop that removes the last remaining item sets empty_o to 1.
- R4: full_o becomes 1 exactly on the 64th consecutive accepted push after empty. Any accepted pop clears full_o.
- R5: A push while full_o is 1, with pop low, is refused. The flags stay as they are, err_o is 1 for one cycle, and the next 64 pops still return the original contents.
- R6: A pop while empty_o is 1, with push low, is refused. dout_o and empty_o are unchanged, and err_o is 1 for one cycle.
- R7: A cycle with push_i and pop_i both high changes nothing. dout_o, full_o and empty_o are unchanged, err_o stays 0, and the next pop returns the top item as it was before that cycle.
- R8: dout_o changes only one cycle after an accepted pop. Pushes and idle cycles leave it unchanged.
- R9: err_o is 1 only in the cycle after a refused push or a refused pop.
- R10: full_o and empty_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe, one item per cycle high |
| pop_i | input | 1 | Pop strobe, one item per cycle high |
| din_i | input | 16 | Word to push |
| dout_o | output | 16 | Most recently popped word, held until the next accepted pop |
| full_o | output | 1 | Stack holds 64 items |
| empty_o | output | 1 | Stack holds no items |
| err_o | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
The hardest state to reach is the full stack. In that state the pointer has wrapped back to zero, just as it is when the stack is empty, and the 64th word sits in location 0. The bench reaches it with a directed run of 64 distinct pushes from reset, checking after every push that the full flag rises only on the last one. It then tries one extra push, which must be refused. Finally it pops all 64 items and checks that the first word out is the one in location 0 and that the order is exactly reversed. A table of short vectors covers the collision, refusal and hold cases around an almost-empty stack.

// File: rtl/reg_stack_pkg.sv
package reg_stack_pkg;

    localparam int unsigned STK_DATA_W = 16;
    localparam int unsigned STK_PTR_W  = 6;

    // Classified request for one cycle
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_PUSH     = 3'd1,
        OP_POP      = 3'd2,
        OP_PUSH_REJ = 3'd3,
        OP_POP_REJ  = 3'd4,
        OP_COLLIDE  = 3'd5
    } stk_op_e;

endpackage

// File: rtl/stack_opdecode.sv
module stack_opdecode
    import reg_stack_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    full_i,
    input  logic    empty_i,
    output stk_op_e op_o
);

    always_comb begin
        unique case ({push_i, pop_i})
            2'b10:   op_o = full_i  ? OP_PUSH_REJ : OP_PUSH;
            2'b01:   op_o = empty_i ? OP_POP_REJ  : OP_POP;
            2'b11:   op_o = OP_COLLIDE;
            default: op_o = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/stack_regfile.sv
module stack_regfile #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] ent_d [DEPTH];
    logic [DATA_W-1:0] ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en_i) begin
            ent_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_q[i] <= ent_d[i];
        end
    end

    assign rd_data_o = ent_q[rd_addr_i];

endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
    import reg_stack_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    typedef struct packed {
        logic [PTR_W-1:0]  sp;
        logic              full;
        logic              empty;
        logic [DATA_W-1:0] dout;
        logic              err;
    } ctrl_s;

    ctrl_s            st_d, st_q;
    logic [PTR_W-1:0] sp_up, sp_dn;

    always_comb begin
        sp_up   = st_q.sp + PTR_W'(1);
        sp_dn   = st_q.sp - PTR_W'(1);
        st_d    = st_q;
        st_d.err = 1'b0;
        wr_en_o = 1'b0;
        unique case (op_i)
            OP_PUSH: begin
                // advance first, then write at the new top
                wr_en_o    = 1'b1;
                st_d.sp    = sp_up;
                st_d.empty = 1'b0;
                st_d.full  = (sp_up == '0);
            end
            OP_POP: begin
                // read the top first, then step back
                st_d.dout  = rd_data_i;
                st_d.sp    = sp_dn;
                st_d.full  = 1'b0;
                st_d.empty = (sp_dn == '0);
            end
            OP_PUSH_REJ, OP_POP_REJ: begin
                st_d.err = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sp: '0, full: 1'b0, empty: 1'b1, dout: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr_o = sp_up;
    assign rd_addr_o = st_q.sp;
    assign dout_o    = st_q.dout;
    assign full_o    = st_q.full;
    assign empty_o   = st_q.empty;
    assign err_o     = st_q.err;

endmodule

// File: rtl/reg_stack.sv
module reg_stack
    import reg_stack_pkg::*;
#(
    parameter int unsigned DATA_W = STK_DATA_W,
    parameter int unsigned PTR_W  = STK_PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    stk_op_e           op;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [PTR_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;

    stack_opdecode u_dec (
        .push_i  (push_i),
        .pop_i   (pop_i),
        .full_i  (full_o),
        .empty_i (empty_o),
        .op_o    (op)
    );

    stack_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .dout_o    (dout_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o)
    );

    stack_regfile #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rf (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (din_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/reg_stack_checker.sv
module reg_stack_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              full_o,
    input logic              empty_o,
    input logic              err_o
);

    logic push_only, pop_only, refused;
    assign push_only = push_i && !pop_i;
    assign pop_only  = pop_i && !push_i;
    assign refused   = (push_only && full_o) || (pop_only && empty_o);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o)); // R10
    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        push_only |=> !empty_o); // R3
    AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pop_only |=> !full_o); // R4
    AST_FULL_PUSH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_only && full_o) |=> (full_o && err_o)); // R5
    AST_EMPTY_POP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_only && empty_o) |=> (empty_o && err_o && $stable(dout_o))); // R6
    AST_COLLIDE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> ($stable(dout_o) && $stable(full_o) && $stable(empty_o) && !err_o)); // R7
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_only |=> $stable(dout_o)); // R8
    AST_ERR_ONLY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !refused |=> !err_o); // R9

endmodule

bind reg_stack reg_stack_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .dout_o  (dout_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
);

// File: tb/tb_reg_stack.sv
module tb_reg_stack;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int NVEC       = 16;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_i, pop_i;
    logic [15:0] din_i;
    logic [15:0] dout_o;
    logic        full_o, empty_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_stack dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .din_i(din_i), .dout_o(dout_o), .full_o(full_o),
        .empty_o(empty_o), .err_o(err_o)
    );

    // {push, pop, din, exp_dout, exp_full, exp_empty, exp_err}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 16'h1111, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3 push clears empty
        {1'b1, 1'b0, 16'h2222, 16'h0000, 1'b0, 1'b0, 1'b0}, // R8
        {1'b1, 1'b0, 16'h3333, 16'h0000, 1'b0, 1'b0, 1'b0}, // R8
        {1'b0, 1'b1, 16'h0000, 16'h3333, 1'b0, 1'b0, 1'b0}, // R2
        {1'b1, 1'b0, 16'h4444, 16'h3333, 1'b0, 1'b0, 1'b0}, // R8 push holds dout
        {1'b1, 1'b1, 16'h5555, 16'h3333, 1'b0, 1'b0, 1'b0}, // R7 collide
        {1'b0, 1'b1, 16'h0000, 16'h4444, 1'b0, 1'b0, 1'b0}, // R7 top unchanged
        {1'b0, 1'b1, 16'h0000, 16'h2222, 1'b0, 1'b0, 1'b0}, // R2
        {1'b0, 1'b1, 16'h0000, 16'h1111, 1'b0, 1'b1, 1'b0}, // R3 last pop sets empty
        {1'b0, 1'b1, 16'h0000, 16'h1111, 1'b0, 1'b1, 1'b1}, // R6 refused pop
        {1'b0, 1'b0, 16'h0000, 16'h1111, 1'b0, 1'b1, 1'b0}, // R9 pulse ends
        {1'b1, 1'b0, 16'h6666, 16'h1111, 1'b0, 1'b0, 1'b0}, // R3
        {1'b1, 1'b1, 16'h7777, 16'h1111, 1'b0, 1'b0, 1'b0}, // R7
        {1'b0, 1'b1, 16'h0000, 16'h6666, 1'b0, 1'b1, 1'b0}, // R2 R3
        {1'b1, 1'b1, 16'h8888, 16'h6666, 1'b0, 1'b1, 1'b0}, // R7 collide while empty
        {1'b0, 1'b1, 16'h0000, 16'h6666, 1'b0, 1'b1, 1'b1}  // R6 R9
    };

    task automatic check(input string req, input logic [15:0] ed,
                         input logic ef, input logic ee, input logic eerr);
        checks++;
        if (dout_o !== ed || full_o !== ef || empty_o !== ee || err_o !== eerr) begin
            fails++;
            $display("FAIL %s: dout=%h full=%b empty=%b err=%b, expected dout=%h full=%b empty=%b err=%b",
                     req, dout_o, full_o, empty_o, err_o, ed, ef, ee, eerr);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic ps, input logic pp, input logic [15:0] d);
        push_i = ps;
        pop_i  = pp;
        din_i  = d;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        push_i = 1'b0;
        pop_i = 1'b0;
        din_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1", 16'h0000, 1'b0, 1'b1, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][36], VEC[v][35], VEC[v][34:19]);
            check($sformatf("vector %0d R2/R3/R6/R7/R8/R9", v),
                  VEC[v][18:3], VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // Directed: full depth, wrap into location 0
        do_reset();
        check("R1 second reset", 16'h0000, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 16'hA000 + 16'(i));
            check("R4 fill", 16'h0000, (i == DEPTH-1), 1'b0, 1'b0);
        end
        step(1'b1, 1'b0, 16'hBEEF);
        check("R5 push refused when full", 16'h0000, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 16'h0000);
        check("R9 pulse one cycle", 16'h0000, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 16'hCAFE);
        check("R7 collide while full", 16'h0000, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b1, 16'h0000);
            check("R2 R4 R5 drain", 16'hA000 + 16'(DEPTH-1-i), 1'b0, (i == DEPTH-1), 1'b0);
        end
        step(1'b0, 1'b1, 16'h0000);
        check("R6 pop refused after drain", 16'hA000, 1'b0, 1'b1, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion within %0d cycles", WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule